// File: doc/BRIEF.md
# Prioritized Peripheral Interrupt Merger

This block gathers eleven peripheral interrupt requests into one request line for a processor core. A rising edge on any request input latches a sticky pending bit for that source. A per-source enable register decides which pending sources may raise the merged line. A vector register shows the table address of the most urgent source that is both pending and enabled.

Sources follow a fixed priority order. Index 0 is the most urgent:

| Index | Source |
|-------|--------|
| 0 | ADC bank A update |
| 1 | PWM sync |
| 2 | ADC bank B update |
| 3 | Combined general-purpose I/O group |
| 4 | Encoder interface |
| 5 | Event timer |
| 6–9 | I/O pins 0, 1, 2, 3 |
| 10 | PWM trip |

Each source owns a four-word slot in the vector table. Slots start at 0x0030 for index 0, so index 10 sits at 0x0058. The core's own interrupt controller is outside the block. Only its enable bit for the shared line comes in, as the input `coreEn`.

Software uses a small register bus with three offsets:

| Offset | Access | Function |
|--------|--------|----------|
| 0 | read/write | Enable mask |
| 1 | read only | Vector |
| 2 | write one to clear | Pending clear |

When the core acknowledges an interrupt with `coreAck`, the block drops the pending bit of the source whose vector is being shown.

Top module: `irqm_top`

## Requirements
- R1: After reset every pending bit and every mask bit is 0, `irqOut` is 0, `vectorOut` is 0x0000, and reading offset 0 returns 0.
- R2: A 0-to-1 transition on `reqIn[i]` sets pending bit i at the next clock edge. A request held high sets it only once, so after the bit is cleared a held level does not set it again.
- R3: A bus write to offset 0 loads `busWrData[10:0]` into the mask at the next edge. Reading offset 0 returns the mask in bits 10:0 with bits 15:11 at zero.
- R4: `irqOut` is high exactly when some source is both pending and mask-enabled while `coreEn` is high.
- R5: `vectorOut` equals 0x0030 + 4·i, where i is the lowest index that is both pending and enabled. It is 0x0000 when no such source exists. Reading offset 1 returns the same value.
- R6: A pending source whose mask bit is 0 is hidden from `irqOut` and `vectorOut` but stays pending. It reappears when its mask bit is set again.
- R7: A bus write to offset 2 clears every pending bit whose data bit is 1 and leaves the others alone. Reading offset 2 returns 0.
- R8: `coreAck` clears only the pending bit of the source shown on `vectorOut` in that cycle. With no enabled pending source it has no effect.
- R9: If a new rising edge on a source arrives in the same cycle as its clear (bus or acknowledge), the pending bit remains set.
- R10: `coreEn` gates only `irqOut`. Pending state and `vectorOut` do not depend on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 11 | Peripheral request lines, index 0 most urgent |
| coreEn | input | 1 | Core-side enable of the shared request line |
| coreAck | input | 1 | Core acknowledge of the shown vector |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 2 | Register offset: 0 mask, 1 vector, 2 pending clear |
| busWrData | input | 16 | Register write data |
| busRdData | output | 16 | Register read data for `busAddr` |
| irqOut | output | 1 | Merged request to the core |
| vectorOut | output | 16 | Vector table address of the winning source |

## Verification
Directed patterns cover the following cases:
- All sources pending under a full mask, acknowledged one at a time. This walks the vector through every slot in priority order.
- A held request after a clear, which separates true edge detection from level sampling.
- A masked-off pending source, which separates hiding a source from discarding it.
- A clear that coincides with a fresh edge, which shows whether set or clear wins.

Random cycles then mix request toggles, mask writes, clears, acknowledges and enable changes. These expose wrong priority, an acknowledge that hits the wrong bit, and gating applied to the vector instead of only to the line.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] OFF_MASK   = 2'd0;
  localparam logic [ADDR_W-1:0] OFF_VECTOR = 2'd1;
  localparam logic [ADDR_W-1:0] OFF_CLEAR  = 2'd2;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic              maskWr;
    logic              clrWr;
    logic              ack;
    logic [DATA_W-1:0] wrData;
  } irqm_strobe_t;
endpackage

// File: rtl/irqm_ctrl.sv
module irqm_ctrl
  import irqm_pkg::*;
#(
  parameter int NUM_SRC = 11
) (
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  input  logic                coreAck,
  input  logic [NUM_SRC-1:0]  maskVec,
  input  logic [DATA_W-1:0]   vectorVal,
  output irqm_strobe_t        strb,
  output logic [DATA_W-1:0]   busRdData
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  always_comb begin
    strb.maskWr = busWrEn && (busAddr == OFF_MASK);
    strb.clrWr  = busWrEn && (busAddr == OFF_CLEAR);
    strb.ack    = coreAck;
    strb.wrData = busWrData;
  end

  always_comb begin
    unique case (busAddr)
      OFF_MASK:   busRdData = {{PAD_W{1'b0}}, maskVec};
      OFF_VECTOR: busRdData = vectorVal;
      default:    busRdData = '0;
    endcase
  end
endmodule

// File: rtl/irqm_datapath.sv
module irqm_datapath
  import irqm_pkg::*;
#(
  parameter int              NUM_SRC  = 11,
  parameter logic [DATA_W-1:0] VEC_BASE = 16'h0030,
  parameter int              VEC_STEP = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  irqm_strobe_t       strb,
  input  logic               coreEn,
  output logic [NUM_SRC-1:0] pendingVec,
  output logic [NUM_SRC-1:0] maskVec,
  output logic [NUM_SRC-1:0] clrBits,
  output logic [DATA_W-1:0]  vectorVal,
  output logic               irqOut
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] reqPrev;
  logic [NUM_SRC-1:0] riseBits;
  logic [NUM_SRC-1:0] activeBits;
  logic [NUM_SRC-1:0] winnerOh;
  logic [IDX_W-1:0]   winnerIdx;
  logic               anyActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPrev <= '0;
      maskVec <= '0;
    end else begin
      reqPrev <= reqIn;
      if (strb.maskWr) maskVec <= strb.wrData[NUM_SRC-1:0];
    end
  end

  assign riseBits   = reqIn & ~reqPrev;
  assign activeBits = pendingVec & maskVec;
  assign anyActive  = |activeBits;

  // Fixed priority: lowest index wins
  always_comb begin
    winnerIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (activeBits[i]) winnerIdx = IDX_W'(i);
    end
    winnerOh = '0;
    if (anyActive) winnerOh[winnerIdx] = 1'b1;
  end

  assign clrBits = (strb.clrWr ? strb.wrData[NUM_SRC-1:0] : '0)
                 | (strb.ack   ? winnerOh                 : '0);

  // One sticky flop per source; a fresh edge beats a clear
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rstN)            pendingVec[g] <= 1'b0;
      else if (riseBits[g]) pendingVec[g] <= 1'b1;
      else if (clrBits[g])  pendingVec[g] <= 1'b0;
    end
  end

  assign vectorVal = anyActive
                   ? VEC_BASE + DATA_W'(VEC_STEP) * DATA_W'(winnerIdx)
                   : '0;
  assign irqOut    = anyActive & coreEn;
endmodule

// File: rtl/irqm_top.sv
module irqm_top
  import irqm_pkg::*;
#(
  parameter int NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic               coreEn,
  input  logic               coreAck,
  input  logic               busWrEn,
  input  logic [1:0]         busAddr,
  input  logic [15:0]        busWrData,
  output logic [15:0]        busRdData,
  output logic               irqOut,
  output logic [15:0]        vectorOut
);
  irqm_strobe_t       strb;
  logic [NUM_SRC-1:0] pendingVec;
  logic [NUM_SRC-1:0] maskVec;
  logic [NUM_SRC-1:0] clrBits;

  irqm_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .coreAck  (coreAck),
    .maskVec  (maskVec),
    .vectorVal(vectorOut),
    .strb     (strb),
    .busRdData(busRdData)
  );

  irqm_datapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .reqIn     (reqIn),
    .strb      (strb),
    .coreEn    (coreEn),
    .pendingVec(pendingVec),
    .maskVec   (maskVec),
    .clrBits   (clrBits),
    .vectorVal (vectorOut),
    .irqOut    (irqOut)
  );
endmodule

// File: rtl/irqm_checker.sv
module irqm_checker #(
  parameter int NUM_SRC = 11
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] reqIn,
  input logic               coreEn,
  input logic               busWrEn,
  input logic [1:0]         busAddr,
  input logic [15:0]        busWrData,
  input logic               irqOut,
  input logic [15:0]        vectorOut,
  input logic [NUM_SRC-1:0] pendingVec,
  input logic [NUM_SRC-1:0] maskVec,
  input logic [NUM_SRC-1:0] clrBits
);
  p_line_gated_r4: assert property (@(posedge clk) disable iff (!rstN)
    !coreEn |-> !irqOut);

  p_vec_idle_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (coreEn && !irqOut) |-> (vectorOut == 16'h0000));

  p_vec_slot_r5: assert property (@(posedge clk) disable iff (!rstN)
    (vectorOut != 16'h0000) |-> (vectorOut[1:0] == 2'b00 &&
      vectorOut >= 16'h0030 && vectorOut <= 16'h0058));

  p_mask_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd0) |=> (maskVec == $past(busWrData[NUM_SRC-1:0])));

  p_pend_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((~pendingVec & $past(pendingVec) & ~$past(clrBits)) == '0));

  p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(reqIn) & ~$past(reqIn, 2)) & ~pendingVec) == '0));
endmodule

bind irqm_top irqm_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqIn     (reqIn),
  .coreEn    (coreEn),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .irqOut    (irqOut),
  .vectorOut (vectorOut),
  .pendingVec(pendingVec),
  .maskVec   (maskVec),
  .clrBits   (clrBits)
);

// File: tb/irqm_top_bench.sv
module irqm_top_bench;
  localparam int N = 11;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  reqIn = '0;
  logic          coreEn = 1'b0;
  logic          coreAck = 1'b0;
  logic          busWrEn = 1'b0;
  logic [1:0]    busAddr = 2'd0;
  logic [15:0]   busWrData = '0;
  logic [15:0]   busRdData;
  logic          irqOut;
  logic [15:0]   vectorOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [N-1:0] pendM = '0, maskM = '0, prevM = '0;

  always #10 clk = ~clk;

  irqm_top u_irqm_top (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .coreEn(coreEn), .coreAck(coreAck),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .irqOut(irqOut), .vectorOut(vectorOut)
  );

  function automatic logic [15:0] expVec(logic [N-1:0] p, logic [N-1:0] m);
    for (int i = 0; i < N; i++)
      if (p[i] && m[i]) return 16'h0030 + 16'(4 * i);
    return 16'h0000;
  endfunction

  function automatic logic [N-1:0] winOh(logic [N-1:0] p, logic [N-1:0] m);
    for (int i = 0; i < N; i++)
      if (p[i] && m[i]) return N'(1) << i;
    return '0;
  endfunction

  function automatic logic [15:0] expRd(logic [1:0] a);
    case (a)
      2'd0: return {5'b0, maskM};
      2'd1: return expVec(pendM, maskM);
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, update the model, sample after the rising edge
  task automatic cyc(logic [N-1:0] r, logic we, logic [1:0] a, logic [15:0] d,
                     logic ack, logic en);
    logic [N-1:0] clr, rise;
    @(negedge clk);
    reqIn = r; busWrEn = we; busAddr = a; busWrData = d; coreAck = ack; coreEn = en;
    rise = r & ~prevM;
    clr  = ((we && a == 2'd2) ? d[N-1:0] : '0) | (ack ? winOh(pendM, maskM) : '0);
    pendM = (pendM & ~clr) | rise;
    if (we && a == 2'd0) maskM = d[N-1:0];
    prevM = r;
    @(posedge clk);
    #5;
  endtask

  task automatic checkAll(string tag);
    check({tag, " R4 irqOut"}, {15'b0, irqOut},
          {15'b0, (|(pendM & maskM)) & coreEn});
    check({tag, " R5 vector"}, vectorOut, expVec(pendM, maskM));
    check({tag, " R3/R5/R7 read"}, busRdData, expRd(busAddr));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #5;
    // R1: reset state
    check("R1 irqOut", {15'b0, irqOut}, 16'h0);
    check("R1 vector", vectorOut, 16'h0);
    check("R1 mask read", busRdData, 16'h0);
    @(negedge clk); rstN = 1'b1;

    // R2: edge sets pending; mask all on so it shows
    cyc('0, 1'b1, 2'd0, 16'hFFFF, 1'b0, 1'b1);
    check("R3 mask read upper zero", busRdData, 16'h07FF);
    cyc(N'(1) << 5, 1'b0, 2'd1, 16'h0, 1'b0, 1'b1);
    check("R2 edge sets event timer", vectorOut, 16'h0044);
    check("R4 line up", {15'b0, irqOut}, 16'h1);
    // R8: ack clears it; held level must not re-pend (R2)
    cyc(N'(1) << 5, 1'b0, 2'd1, 16'h0, 1'b1, 1'b1);
    check("R8 ack clears", vectorOut, 16'h0000);
    cyc(N'(1) << 5, 1'b0, 2'd1, 16'h0, 1'b0, 1'b1);
    check("R2 held level no repend", vectorOut, 16'h0000);
    cyc('0, 1'b0, 2'd1, 16'h0, 1'b0, 1'b1);

    // R5/R8: all pending, walk the priority order by acknowledges
    cyc('1, 1'b0, 2'd1, 16'h0, 1'b0, 1'b1);
    for (int i = 0; i < N; i++) begin
      check("R5 priority walk", vectorOut, 16'h0030 + 16'(4 * i));
      cyc('1, 1'b0, 2'd1, 16'h0, 1'b1, 1'b1);
    end
    check("R8 walk end", vectorOut, 16'h0000);
    cyc('0, 1'b0, 2'd1, 16'h0, 1'b1, 1'b1);
    check("R8 ack with none pending", vectorOut, 16'h0000);

    // R6: mask hides without discarding
    cyc(N'(1) << 10, 1'b1, 2'd0, 16'h0000, 1'b0, 1'b1);
    check("R6 hidden line", {15'b0, irqOut}, 16'h0);
    check("R6 hidden vector", vectorOut, 16'h0000);
    cyc('0, 1'b1, 2'd0, 16'h0400, 1'b0, 1'b1);
    check("R6 reappears", vectorOut, 16'h0058);

    // R10: enable low gates only the line
    cyc('0, 1'b0, 2'd1, 16'h0, 1'b0, 1'b0);
    check("R10 line gated", {15'b0, irqOut}, 16'h0);
    check("R10 vector kept", busRdData, 16'h0058);

    // R7 and R9: clear with simultaneous new edge on source 0
    cyc('0, 1'b1, 2'd0, 16'h07FF, 1'b0, 1'b1);
    cyc(N'(1) << 0, 1'b1, 2'd2, 16'h0401, 1'b0, 1'b1);
    check("R9 set beats clear", vectorOut, 16'h0030);
    check("R7 clear reads zero", busRdData, 16'h0000);
    cyc(N'(1) << 0, 1'b1, 2'd2, 16'h0001, 1'b0, 1'b1);
    check("R7 clear empties", vectorOut, 16'h0000);

    // Random mix
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] rv;
      rv = $urandom;
      cyc(reqIn ^ (rv[10:0] & (rv[11] ? 11'h0FF : 11'h700)),
          rv[14:12] == 3'd0, rv[16:15] % 3,
          16'($urandom), rv[19:17] == 3'd0, rv[22:20] != 3'd0);
      checkAll("random");
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule